// File: doc/BRIEF.md
# Peripheral security protection controller

This block decides, for every securable peripheral in a subsystem, whether a given bus access may reach it. Each peripheral ID owns a 2-bit access attribute stored in the controller. The attribute either keeps the peripheral secure-only, opens reads to the non-secure world, opens reads and writes, or reserves it for the microcontroller master. Downstream firewalls present, per ID, the security flag, the direction and the master tag of a pending transaction and receive a combinational grant.

Software programs the attributes, a small set of per-zone secure-size values and their locks through an APB register slave. The slave answers only to secure accesses. A lock is sticky until reset: a locked ID or zone ignores every later write. Read-only registers report the build counts and a revision byte. The slave has no wait states. The read data and error response are captured in the setup phase and presented in the access phase.

Top module: `periph_guard`

## Requirements
- R1: After reset every attribute word, lock word and zone register reads 0.
- R2: The attribute of ID n sits in the word at byte offset 0x010 + 4*(n/16), bits [2*(n%16)+1 : 2*(n%16)]. A secure write stores it and a secure read returns it.
- R3: Lock bits sit at offset 0x030 + 4*(n/32), bit n%32. Writing 1 sets the bit and writing 0 leaves it unchanged, so a set lock bit cannot be cleared by software.
- R4: A write to an attribute word leaves the fields of locked IDs unchanged and updates the fields of unlocked IDs in the same word.
- R5: Zone z has a register at offset 4*z, with the size in bits [9:0] and a lock in bit 31. All other bits read 0. Once bit 31 is set, writes to that zone are ignored.
- R6: Writes to IDs at or beyond NUM_ID, or to zones at or beyond NUM_ZONE, are ignored, and those fields read 0.
- R7: Offset 0x3F0 reads {chunk steps[31:24], master count[23:16], NUM_ID[15:8], NUM_ZONE[7:0]}. Offset 0x3F4 reads the revision in bits [7:0]. Unmapped offsets read 0.
- R8: An access with pprot[1]=1 (non-secure) gets pslverr=1 and prdata=0 in its access phase, and its write is ignored. A secure access gets pslverr=0.
- R9: Attribute encodings are 0 = secure only, 1 = non-secure read allowed, 3 = non-secure read and write allowed. For these, grant[n] = !req_ns[n] | attr==3 | (attr==1 & !req_wr[n]).
- R10: Under attribute 2, grant[n] equals req_mcu[n], whatever the security flag and direction.
- R11: pready is always 1. An attribute written in an access phase changes grant from the cycle after that access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| prst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| pprot | input | 3 | APB protection; bit 1 set marks non-secure |
| paddr | input | 10 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error for non-secure accesses |
| req_ns | input | NUM_ID | Per-ID transaction non-secure flag |
| req_wr | input | NUM_ID | Per-ID transaction write flag |
| req_mcu | input | NUM_ID | Per-ID transaction microcontroller-master flag |
| grant | output | NUM_ID | Per-ID access permit |

## Verification
The register slave can rewrite an attribute in the same cycle that the permit logic evaluates a live request for that ID. The bench holds a non-secure read request on one ID and writes that ID's attribute word. It checks that the grant is still denied during the access phase and is granted just after the access edge. The same collision occurs between a lock write and an attribute write to the same ID. The bench locks first, then writes the attribute word, and judges the result by reading back both the locked and the unlocked fields of that word.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int ADDR_W    = 10;
  localparam int WADDR_W   = ADDR_W - 2;
  localparam int DATA_W    = 32;
  localparam int ATTR_WORDS = 8;
  localparam int LOCK_WORDS = 4;
  localparam int MAX_ZONES  = 4;
  localparam logic [WADDR_W-1:0] CFG_WADDR = 8'hFC;
  localparam logic [WADDR_W-1:0] VER_WADDR = 8'hFD;

  typedef enum logic [1:0] {
    ATTR_SEC_ONLY = 2'd0,
    ATTR_NS_READ  = 2'd1,
    ATTR_MCU_ONLY = 2'd2,
    ATTR_OPEN     = 2'd3
  } attr_e;
endpackage

// File: rtl/pg_attr_bank.sv
module pg_attr_bank #(
  parameter int NUM_ID = 96
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                attr_we,
  input  logic                lock_we,
  input  logic [2:0]          aword,
  input  logic [1:0]          lword,
  input  logic [31:0]         wdata,
  output logic [2*NUM_ID-1:0] attr_vec,
  output logic [NUM_ID-1:0]   lock_vec,
  output logic [31:0]         attr_rd,
  output logic [31:0]         lock_rd
);
  localparam int ATTR_BITS = pg_pkg::ATTR_WORDS * 32;
  localparam int LOCK_BITS = pg_pkg::LOCK_WORDS * 32;

  logic [ATTR_BITS-1:0] attr_pad;
  logic [LOCK_BITS-1:0] lock_pad;

  for (genvar i = 0; i < NUM_ID; i++) begin : g_id
    localparam int AW = i / 16;
    localparam int AB = 2 * (i % 16);
    localparam int LW = i / 32;
    localparam int LB = i % 32;

    always_ff @(posedge clk) begin
      if (rst) begin
        attr_vec[2*i +: 2] <= 2'd0;
      end else if (attr_we && aword == 3'(AW) && !lock_vec[i]) begin
        attr_vec[2*i +: 2] <= wdata[AB +: 2];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_vec[i] <= 1'b0;
      end else if (lock_we && lword == 2'(LW) && wdata[LB]) begin
        lock_vec[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    attr_pad = '0;
    attr_pad[2*NUM_ID-1:0] = attr_vec;
    lock_pad = '0;
    lock_pad[NUM_ID-1:0] = lock_vec;
  end

  assign attr_rd = attr_pad[{aword, 5'b0} +: 32];
  assign lock_rd = lock_pad[{lword, 5'b0} +: 32];
endmodule

// File: rtl/pg_zone_bank.sv
module pg_zone_bank #(
  parameter int NUM_ZONE = 2,
  parameter int SIZE_W   = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [1:0]          zidx,
  input  logic [31:0]         wdata,
  output logic [NUM_ZONE-1:0] zlock,
  output logic [31:0]         zone_rd
);
  logic [SIZE_W-1:0] size_q [NUM_ZONE];
  logic unused_hi;

  assign unused_hi = ^wdata[30:SIZE_W];

  for (genvar z = 0; z < NUM_ZONE; z++) begin : g_zone
    always_ff @(posedge clk) begin
      if (rst) begin
        size_q[z] <= '0;
        zlock[z]  <= 1'b0;
      end else if (we && zidx == 2'(z) && !zlock[z]) begin
        size_q[z] <= wdata[SIZE_W-1:0];
        zlock[z]  <= wdata[31];
      end
    end
  end

  always_comb begin
    zone_rd = '0;
    for (int z = 0; z < NUM_ZONE; z++) begin
      if (zidx == 2'(z)) zone_rd = {zlock[z], {(31-SIZE_W){1'b0}}, size_q[z]};
    end
  end
endmodule

// File: rtl/pg_permit.sv
module pg_permit #(
  parameter int NUM_ID = 96
) (
  input  logic [2*NUM_ID-1:0] attr_vec,
  input  logic [NUM_ID-1:0]   req_ns,
  input  logic [NUM_ID-1:0]   req_wr,
  input  logic [NUM_ID-1:0]   req_mcu,
  output logic [NUM_ID-1:0]   grant
);
  import pg_pkg::*;

  for (genvar i = 0; i < NUM_ID; i++) begin : g_dec
    attr_e a;
    assign a = attr_e'(attr_vec[2*i +: 2]);
    always_comb begin
      case (a)
        ATTR_SEC_ONLY: grant[i] = !req_ns[i];
        ATTR_NS_READ:  grant[i] = !req_ns[i] || !req_wr[i];
        ATTR_MCU_ONLY: grant[i] = req_mcu[i];
        default:       grant[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/periph_guard.sv
module periph_guard #(
  parameter int NUM_ID      = 96,
  parameter int NUM_ZONE    = 2,
  parameter int SIZE_W      = 10,
  parameter int NUM_MST     = 2,
  parameter int CHUNK_STEPS = 3,
  parameter int REVISION    = 16
) (
  input  logic              pclk,
  input  logic              prst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [2:0]        pprot,
  input  logic [9:0]        paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NUM_ID-1:0] req_ns,
  input  logic [NUM_ID-1:0] req_wr,
  input  logic [NUM_ID-1:0] req_mcu,
  output logic [NUM_ID-1:0] grant
);
  import pg_pkg::*;

  localparam logic [31:0] HWCFG = {8'(CHUNK_STEPS), 8'(NUM_MST), 8'(NUM_ID), 8'(NUM_ZONE)};
  localparam logic [31:0] VERSION = {24'd0, 8'(REVISION)};

  logic [WADDR_W-1:0] waddr;
  logic [WADDR_W-1:0] aoff;
  logic               is_ns;
  logic               acc_wr;
  logic               hit_zone, hit_attr, hit_lock;
  logic [2*NUM_ID-1:0] attr_vec;
  logic [NUM_ID-1:0]  lock_vec;
  logic [NUM_ZONE-1:0] zone_lock;
  logic [31:0]        attr_rd, lock_rd, zone_rd, rd_mux;
  logic [31:0]        rdata_q;
  logic               err_q;
  logic               unused_bits;

  assign unused_bits = ^{pprot[2], pprot[0], paddr[1:0]};

  assign waddr    = paddr[ADDR_W-1:2];
  assign aoff     = waddr - WADDR_W'(4);
  assign is_ns    = pprot[1];
  assign acc_wr   = psel && penable && pwrite && !is_ns;
  assign hit_zone = waddr < WADDR_W'(MAX_ZONES);
  assign hit_attr = waddr >= WADDR_W'(4) && waddr < WADDR_W'(12);
  assign hit_lock = waddr >= WADDR_W'(12) && waddr < WADDR_W'(16);

  pg_attr_bank #(.NUM_ID(NUM_ID)) u_attr (
    .clk     (pclk),
    .rst     (prst),
    .attr_we (acc_wr && hit_attr),
    .lock_we (acc_wr && hit_lock),
    .aword   (aoff[2:0]),
    .lword   (waddr[1:0]),
    .wdata   (pwdata),
    .attr_vec(attr_vec),
    .lock_vec(lock_vec),
    .attr_rd (attr_rd),
    .lock_rd (lock_rd)
  );

  pg_zone_bank #(.NUM_ZONE(NUM_ZONE), .SIZE_W(SIZE_W)) u_zone (
    .clk    (pclk),
    .rst    (prst),
    .we     (acc_wr && hit_zone),
    .zidx   (waddr[1:0]),
    .wdata  (pwdata),
    .zlock  (zone_lock),
    .zone_rd(zone_rd)
  );

  pg_permit #(.NUM_ID(NUM_ID)) u_permit (
    .attr_vec(attr_vec),
    .req_ns  (req_ns),
    .req_wr  (req_wr),
    .req_mcu (req_mcu),
    .grant   (grant)
  );

  always_comb begin
    if (hit_zone)              rd_mux = zone_rd;
    else if (hit_attr)         rd_mux = attr_rd;
    else if (hit_lock)         rd_mux = lock_rd;
    else if (waddr == CFG_WADDR) rd_mux = HWCFG;
    else if (waddr == VER_WADDR) rd_mux = VERSION;
    else                       rd_mux = '0;
  end

  always_ff @(posedge pclk) begin
    if (prst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (psel && !penable) begin
      rdata_q <= is_ns ? '0 : rd_mux;
      err_q   <= is_ns;
    end
  end

  assign prdata  = rdata_q;
  assign pslverr = err_q;
  assign pready  = 1'b1;
endmodule

// File: rtl/pg_chk.sv
module pg_chk #(
  parameter int NUM_ID   = 96,
  parameter int NUM_ZONE = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [2:0]          pprot,
  input logic [31:0]         prdata,
  input logic                pslverr,
  input logic [2*NUM_ID-1:0] attr_vec,
  input logic [NUM_ID-1:0]   lock_vec,
  input logic [NUM_ZONE-1:0] zlock,
  input logic [NUM_ID-1:0]   req_ns,
  input logic [NUM_ID-1:0]   req_wr,
  input logic [NUM_ID-1:0]   req_mcu,
  input logic [NUM_ID-1:0]   grant
);
  // R8
  ns_err_chk: assert property (@(posedge clk) disable iff (rst)
    psel && penable && pprot[1] |-> pslverr && prdata == 32'd0);

  // R8
  ns_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    psel && penable && pwrite && pprot[1] |=> $stable(attr_vec) && $stable(lock_vec) && $stable(zlock));

  for (genvar z = 0; z < NUM_ZONE; z++) begin : g_z
    // R5
    zone_lock_chk: assert property (@(posedge clk) disable iff (rst)
      zlock[z] |=> zlock[z]);
  end

  for (genvar i = 0; i < NUM_ID; i++) begin : g_i
    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      lock_vec[i] |=> lock_vec[i]);

    // R4
    locked_attr_chk: assert property (@(posedge clk) disable iff (rst)
      lock_vec[i] |=> $stable(attr_vec[2*i +: 2]));

    // R9
    sec_grant_chk: assert property (@(posedge clk) disable iff (rst)
      !req_ns[i] && attr_vec[2*i +: 2] != 2'd2 |-> grant[i]);

    // R9
    ns_deny_chk: assert property (@(posedge clk) disable iff (rst)
      req_ns[i] && attr_vec[2*i +: 2] == 2'd0 |-> !grant[i]);

    // R10
    mcu_only_chk: assert property (@(posedge clk) disable iff (rst)
      attr_vec[2*i +: 2] == 2'd2 |-> grant[i] == req_mcu[i]);

    logic unused_wr;
    assign unused_wr = req_wr[i];
  end
endmodule

bind periph_guard pg_chk #(.NUM_ID(NUM_ID), .NUM_ZONE(NUM_ZONE)) u_chk (
  .clk     (pclk),
  .rst     (prst),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .pprot   (pprot),
  .prdata  (prdata),
  .pslverr (pslverr),
  .attr_vec(attr_vec),
  .lock_vec(lock_vec),
  .zlock   (zone_lock),
  .req_ns  (req_ns),
  .req_wr  (req_wr),
  .req_mcu (req_mcu),
  .grant   (grant)
);

// File: tb/tb_periph_guard.sv
module tb_periph_guard;
  localparam int NID = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [2:0] pprot = 3'd0;
  logic [9:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [NID-1:0] req_ns = '0, req_wr = '0, req_mcu = '0;
  logic [NID-1:0] grant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isrd;
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  periph_guard dut (
    .pclk(clk), .prst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pprot(pprot), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .req_ns(req_ns), .req_wr(req_wr),
    .req_mcu(req_mcu), .grant(grant)
  );

  // monitor: pops expectations in the access phase
  always @(posedge clk) begin
    #1;
    if (psel && penable) begin
      exp_t x;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected transfer act=%h exp=none", "R8", prdata);
      end else begin
        x = q.pop_front();
        checks++;
        if (pready !== 1'b1 || pslverr !== x.e || (x.isrd && prdata !== x.d)) begin
          errors++;
          $display("FAIL %s act rdata=%h err=%b rdy=%b exp rdata=%h err=%b rdy=1",
                   x.tag, prdata, pslverr, pready, x.d, x.e);
        end
      end
    end
  end

  task automatic apb(input bit wr, input bit ns, input logic [9:0] a,
                     input logic [31:0] d, input logic [31:0] ex, input string tag);
    exp_t x;
    x.isrd = !wr; x.d = ex; x.e = ns; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    pprot = {1'b0, ns, 1'b0};
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] ex, input string tag);
    apb(1'b0, 1'b0, a, 32'd0, ex, tag);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
    apb(1'b1, 1'b0, a, d, 32'd0, tag);
  endtask

  task automatic chk_grant(input int id, input bit ns, input bit w, input bit m,
                           input bit ex, input string tag);
    @(negedge clk);
    req_ns = {NID{ns}}; req_wr = {NID{w}}; req_mcu = {NID{m}};
    #1;
    checks++;
    if (grant[id] !== ex) begin
      errors++;
      $display("FAIL %s id=%0d act=%b exp=%b", tag, id, grant[id], ex);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R7 config/version
    rd(10'h010, 32'd0, "R1");
    rd(10'h030, 32'd0, "R1");
    rd(10'h000, 32'd0, "R1");
    rd(10'h004, 32'd0, "R1");
    rd(10'h3F0, 32'h0302_6002, "R7");
    rd(10'h3F4, 32'h0000_0010, "R7");
    rd(10'h100, 32'd0, "R7");

    // R11 write versus live permit on ID17 in the same cycle
    chk_grant(17, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    begin
      exp_t x;
      x.isrd = 1'b0; x.d = 0; x.e = 1'b0; x.tag = "R11";
      q.push_back(x);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 10'h014;
      pwdata = 32'h0000_00E4; pprot = 3'd0;
      @(negedge clk);
      penable = 1'b1;
      #1;
      checks++;
      if (grant[17] !== 1'b0) begin
        errors++; $display("FAIL R11 pre-edge act=%b exp=0", grant[17]);
      end
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
      checks++;
      if (grant[17] !== 1'b1) begin
        errors++; $display("FAIL R11 post-edge act=%b exp=1", grant[17]);
      end
    end
    rd(10'h014, 32'h0000_00E4, "R2");

    // R2 packing
    wr(10'h010, 32'hFFFF_FFFF, "R2");
    rd(10'h010, 32'hFFFF_FFFF, "R2");
    wr(10'h024, 32'h1234_5678, "R2");
    rd(10'h024, 32'h1234_5678, "R2");

    // R6 out of range
    wr(10'h028, 32'hFFFF_FFFF, "R6");
    rd(10'h028, 32'd0, "R6");
    wr(10'h03C, 32'hFFFF_FFFF, "R6");
    rd(10'h03C, 32'd0, "R6");
    wr(10'h008, 32'h0000_03FF, "R6");
    rd(10'h008, 32'd0, "R6");

    // R3 lock write-one-to-set
    wr(10'h030, 32'h0000_0004, "R3");
    rd(10'h030, 32'h0000_0004, "R3");
    wr(10'h030, 32'h0000_0001, "R3");
    rd(10'h030, 32'h0000_0005, "R3");
    wr(10'h030, 32'h0000_0000, "R3");
    rd(10'h030, 32'h0000_0005, "R3");
    wr(10'h038, 32'h8000_0000, "R3");
    rd(10'h038, 32'h8000_0000, "R3");

    // R4 locked IDs 0 and 2 keep attribute 3
    wr(10'h010, 32'h0000_0000, "R4");
    rd(10'h010, 32'h0000_0033, "R4");

    // R5 zones
    wr(10'h000, 32'h0000_F3FF, "R5");
    rd(10'h000, 32'h0000_03FF, "R5");
    wr(10'h004, 32'h8000_0155, "R5");
    rd(10'h004, 32'h8000_0155, "R5");
    wr(10'h004, 32'h0000_03FF, "R5");
    rd(10'h004, 32'h8000_0155, "R5");

    // R8 non-secure accesses
    apb(1'b0, 1'b1, 10'h010, 32'd0, 32'd0, "R8");
    apb(1'b1, 1'b1, 10'h014, 32'hFFFF_FFFF, 32'd0, "R8");
    rd(10'h014, 32'h0000_00E4, "R8");
    apb(1'b1, 1'b1, 10'h030, 32'hFFFF_FFFF, 32'd0, "R8");
    rd(10'h030, 32'h0000_0005, "R8");
    apb(1'b0, 1'b1, 10'h3F0, 32'd0, 32'd0, "R8");

    // R9 attributes 0, 1, 3 on IDs 16, 17, 19
    chk_grant(16, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    chk_grant(16, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    chk_grant(16, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    chk_grant(17, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    chk_grant(17, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    chk_grant(17, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
    chk_grant(19, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
    // R10 attribute 2 on ID 18
    chk_grant(18, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
    chk_grant(18, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    chk_grant(18, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    chk_grant(18, 1'b0, 1'b0, 1'b1, 1'b1, "R10");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R8 pending act=%0d exp=0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule